// File: doc/BRIEF.md
# Associative Page Translation Buffer

This block caches recent page translations for a processor's memory path. A 32-bit virtual address is split into a 20-bit page number and a 12-bit offset (4 KiB pages). The page number is compared against every stored entry in parallel. On a match the block joins the stored frame number to the untouched offset and returns the physical address in the same cycle. It also returns the entry's access rights and decides right away whether the requested access is allowed.

When no entry matches, the block raises a miss flag. An external table walker then looks up the translation and writes it back through the refill port. The new entry can be used from the following cycle. A flush input invalidates every entry at once. A refill goes to the entry that already holds that page if there is one. Otherwise it goes to the lowest-numbered empty entry, and when no entry is empty, to the entry named by a rotating pointer.

Top module: `pgmap_tlb`

## Requirements
- R1: After reset every entry is invalid, and each lookup reports a miss.
- R2: When `lk_valid` is high and a valid entry holds page number `lk_vaddr[31:12]` with the access permitted, `lk_hit` is 1 in the same cycle. `lk_paddr` is `{frame, lk_vaddr[11:0]}` and `lk_perm` is the entry's rights.
- R3: When `lk_valid` is high and no valid entry matches, `lk_miss` is 1, `lk_hit` and `lk_fault` are 0, and `lk_paddr` and `lk_perm` are 0.
- R4: Rights are coded as bit 0 = read, bit 1 = write, bit 2 = execute. Access codes are 0 = load, 1 = store, 2 = fetch, and 3 is treated as a load. On a match whose needed right is clear, `lk_fault` is 1 and `lk_hit` is 0, while `lk_paddr` and `lk_perm` still carry the translation.
- R5: While `lk_valid` is low, all flags, `lk_paddr` and `lk_perm` are 0.
- R6: A refill presented with `fill_en` is stored at the next rising clock edge. A lookup in that same cycle still sees the old contents.
- R7: Refilling a page number that is already held overwrites that entry, so a page never occupies two entries.
- R8: A refill of a page that is not held goes to the lowest-numbered invalid entry when one exists.
- R9: When all 32 entries are valid, a refill of a page that is not held replaces the entry at the rotating pointer. The pointer then advances by one, wrapping from 31 to 0. The pointer is 0 after reset and moves on no other event.
- R10: `flush` invalidates all entries at the next edge and leaves the rotating pointer unchanged.
- R11: When `flush` and `fill_en` are high in the same cycle, the flush wins and the refill is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_acc | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| lk_hit | output | 1 | Translation found and access allowed |
| lk_miss | output | 1 | No entry holds the page |
| lk_fault | output | 1 | Entry found but access not allowed |
| lk_paddr | output | 32 | Physical address |
| lk_perm | output | 3 | Rights of the matched entry |
| fill_en | input | 1 | Write a refill entry |
| fill_vpn | input | 20 | Page number of the refill |
| fill_pfn | input | 20 | Frame number of the refill |
| fill_perm | input | 3 | Rights of the refill |
| flush | input | 1 | Invalidate all entries |

## Verification
Two pairs of functions can act in the same cycle: a lookup alongside a refill, and a flush alongside a refill. The bench drives a lookup of the page being refilled during the refill cycle and expects a miss, then expects a hit one cycle later. It also raises flush together with a refill and then confirms that neither the new page nor any older page hits. A behavioural model built from arrays and an integer pointer tracks every edge, and the outputs are compared with it on every cycle, so eviction order after a flush is checked as well.

// File: rtl/pgmap_pkg.sv
package pgmap_pkg;
  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef struct packed {
    logic x;
    logic w;
    logic r;
  } perm_t;
endpackage

// File: rtl/pgmap_cam.sv
module pgmap_cam #(
  parameter int ENTRIES = 32,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic                       wr_en,
  input  logic [$clog2(ENTRIES)-1:0] wr_idx,
  input  logic [VPN_W-1:0]           wr_vpn,
  input  logic [PFN_W-1:0]           wr_pfn,
  input  pgmap_pkg::perm_t           wr_perm,
  input  logic [VPN_W-1:0]           look_vpn,
  output logic [ENTRIES-1:0]         look_match,
  output logic [PFN_W-1:0]           look_pfn,
  output pgmap_pkg::perm_t           look_perm,
  output logic [ENTRIES-1:0]         probe_match,
  output logic [ENTRIES-1:0]         valid_vec
);
  import pgmap_pkg::*;
  localparam int IDX_W = $clog2(ENTRIES);

  logic [ENTRIES-1:0] valid_q, valid_d, sel_vec;
  logic [VPN_W-1:0]   vpn_q  [ENTRIES];
  logic [PFN_W-1:0]   pfn_q  [ENTRIES];
  perm_t              perm_q [ENTRIES];
  logic               wr_go;

  // flush has priority over a refill in the same cycle
  assign wr_go = wr_en && !flush;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    assign sel_vec[e]     = wr_go && (wr_idx == IDX_W'(e));
    assign valid_d[e]     = flush ? 1'b0 : (sel_vec[e] | valid_q[e]);
    assign look_match[e]  = valid_q[e] && (vpn_q[e] == look_vpn);
    assign probe_match[e] = valid_q[e] && (vpn_q[e] == wr_vpn);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    for (int e = 0; e < ENTRIES; e++) begin
      if (sel_vec[e]) begin
        vpn_q[e]  <= wr_vpn;
        pfn_q[e]  <= wr_pfn;
        perm_q[e] <= wr_perm;
      end
    end
  end

  always_comb begin
    look_pfn  = '0;
    look_perm = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (look_match[e]) begin
        look_pfn  = look_pfn | pfn_q[e];
        look_perm = look_perm | perm_q[e];
      end
    end
  end

  assign valid_vec = valid_q;

  // R7
  single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(look_match));

  // R11
  flush_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && wr_en) |=> (valid_q == '0));
endmodule

// File: rtl/pgmap_victim.sv
module pgmap_victim #(
  parameter int ENTRIES = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       fill_go,
  input  logic [ENTRIES-1:0]         probe_match,
  input  logic [ENTRIES-1:0]         valid_vec,
  output logic [$clog2(ENTRIES)-1:0] wr_idx
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] ptr_q, ptr_d;
  logic [IDX_W-1:0] probe_idx, free_idx;
  logic             have_probe, have_free, use_ptr;

  always_comb begin
    probe_idx = '0;
    for (int e = ENTRIES - 1; e >= 0; e--) begin
      if (probe_match[e]) probe_idx = IDX_W'(e);
    end
  end

  always_comb begin
    free_idx = '0;
    for (int e = ENTRIES - 1; e >= 0; e--) begin
      if (!valid_vec[e]) free_idx = IDX_W'(e);
    end
  end

  assign have_probe = |probe_match;
  assign have_free  = !(&valid_vec);
  assign use_ptr    = !have_probe && !have_free;

  always_comb begin
    if (have_probe)     wr_idx = probe_idx;
    else if (have_free) wr_idx = free_idx;
    else                wr_idx = ptr_q;
  end

  always_comb begin
    ptr_d = ptr_q;
    if (fill_go && use_ptr) ptr_d = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  // R9
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fill_go && use_ptr) |=> (ptr_q == $past(ptr_q)));

  // R8
  free_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_go && !have_probe && have_free) |-> !valid_vec[wr_idx]);
endmodule

// File: rtl/pgmap_perm_chk.sv
module pgmap_perm_chk (
  input  logic              hit_raw,
  input  pgmap_pkg::acc_e   acc,
  input  pgmap_pkg::perm_t  perm,
  output logic              fault
);
  import pgmap_pkg::*;
  logic granted;

  always_comb begin
    unique case (acc)
      ACC_STORE: granted = perm.w;
      ACC_FETCH: granted = perm.x;
      default:   granted = perm.r;
    endcase
  end

  assign fault = hit_raw && !granted;
endmodule

// File: rtl/pgmap_tlb.sv
module pgmap_tlb #(
  parameter int ENTRIES = 32,
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int OFF_W   = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  lk_valid,
  input  logic [VA_W-1:0]       lk_vaddr,
  input  logic [1:0]            lk_acc,
  output logic                  lk_hit,
  output logic                  lk_miss,
  output logic                  lk_fault,
  output logic [PA_W-1:0]       lk_paddr,
  output logic [2:0]            lk_perm,
  input  logic                  fill_en,
  input  logic [VA_W-OFF_W-1:0] fill_vpn,
  input  logic [PA_W-OFF_W-1:0] fill_pfn,
  input  logic [2:0]            fill_perm,
  input  logic                  flush
);
  import pgmap_pkg::*;
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PFN_W = PA_W - OFF_W;
  localparam int IDX_W = $clog2(ENTRIES);

  logic [ENTRIES-1:0] look_match, probe_match, valid_vec;
  logic [PFN_W-1:0]   look_pfn;
  perm_t              look_perm;
  logic [IDX_W-1:0]   wr_idx;
  logic               hit_raw, fault;

  pgmap_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W)) cam_i (
    .clk(clk), .rst_n(rst_n), .flush(flush), .wr_en(fill_en),
    .wr_idx(wr_idx), .wr_vpn(fill_vpn), .wr_pfn(fill_pfn),
    .wr_perm(perm_t'(fill_perm)), .look_vpn(lk_vaddr[VA_W-1:OFF_W]),
    .look_match(look_match), .look_pfn(look_pfn), .look_perm(look_perm),
    .probe_match(probe_match), .valid_vec(valid_vec)
  );

  pgmap_victim #(.ENTRIES(ENTRIES)) victim_i (
    .clk(clk), .rst_n(rst_n), .fill_go(fill_en && !flush),
    .probe_match(probe_match), .valid_vec(valid_vec), .wr_idx(wr_idx)
  );

  assign hit_raw = lk_valid && (|look_match);

  pgmap_perm_chk perm_i (
    .hit_raw(hit_raw), .acc(acc_e'(lk_acc)), .perm(look_perm), .fault(fault)
  );

  assign lk_hit   = hit_raw && !fault;
  assign lk_fault = fault;
  assign lk_miss  = lk_valid && !(|look_match);
  assign lk_paddr = hit_raw ? {look_pfn, lk_vaddr[OFF_W-1:0]} : '0;
  assign lk_perm  = hit_raw ? look_perm : 3'b000;

  // R5
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> (!lk_hit && !lk_miss && !lk_fault && lk_paddr == '0));

  // R2
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> $onehot({lk_hit, lk_miss, lk_fault}));

  // R4
  fault_keeps_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_fault |-> (lk_paddr[OFF_W-1:0] == lk_vaddr[OFF_W-1:0] && !lk_hit));

  // R10
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!lk_hit && !lk_fault));
endmodule

// File: tb/pgmap_tlb_tb_top.sv
`timescale 1ns/1ps
module pgmap_tlb_tb_top;
  localparam int N = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic [1:0]  lk_acc = '0;
  logic        lk_hit, lk_miss, lk_fault;
  logic [31:0] lk_paddr;
  logic [2:0]  lk_perm;
  logic        fill_en = 1'b0;
  logic [19:0] fill_vpn = '0;
  logic [19:0] fill_pfn = '0;
  logic [2:0]  fill_perm = '0;
  logic        flush = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // behavioural reference state
  bit        m_val  [N];
  int        m_vpn  [N];
  int        m_pfn  [N];
  int        m_perm [N];
  int        m_ptr;

  always #4 clk = ~clk;

  pgmap_tlb dut_i (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
    .lk_acc(lk_acc), .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_fault(lk_fault),
    .lk_paddr(lk_paddr), .lk_perm(lk_perm), .fill_en(fill_en),
    .fill_vpn(fill_vpn), .fill_pfn(fill_pfn), .fill_perm(fill_perm),
    .flush(flush)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < N; e++) m_val[e] = 1'b0;
      m_ptr = 0;
    end else if (flush) begin
      for (int e = 0; e < N; e++) m_val[e] = 1'b0;
    end else if (fill_en) begin
      int slot;
      slot = -1;
      for (int e = 0; e < N; e++)
        if (slot < 0 && m_val[e] && m_vpn[e] == int'(fill_vpn)) slot = e;
      for (int e = 0; e < N; e++)
        if (slot < 0 && !m_val[e]) slot = e;
      if (slot < 0) begin
        slot = m_ptr;
        m_ptr = (m_ptr + 1) % N;
      end
      m_val[slot]  = 1'b1;
      m_vpn[slot]  = int'(fill_vpn);
      m_pfn[slot]  = int'(fill_pfn);
      m_perm[slot] = int'(fill_perm);
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit eh, em, ef, ok;
      logic [31:0] epa;
      logic [2:0]  epm;
      int idx;
      string tag;
      idx = -1;
      for (int e = 0; e < N; e++)
        if (m_val[e] && m_vpn[e] == int'(lk_vaddr[31:12])) idx = e;
      eh = 0; em = 0; ef = 0; epa = '0; epm = '0;
      if (!lk_valid) tag = "R5";
      else if (idx < 0) begin em = 1; tag = "R3"; end
      else begin
        epm = 3'(m_perm[idx]);
        epa = {20'(m_pfn[idx]), lk_vaddr[11:0]};
        ok = (lk_acc == 2'd1) ? epm[1] : (lk_acc == 2'd2) ? epm[2] : epm[0];
        if (ok) begin eh = 1; tag = "R2"; end
        else    begin ef = 1; tag = "R4"; end
      end
      checks++;
      if ({lk_hit, lk_miss, lk_fault} != {eh, em, ef} || lk_paddr != epa || lk_perm != epm) begin
        errors++;
        $display("FAIL %s model: hmf=%b pa=%h pm=%b expected hmf=%b pa=%h pm=%b",
                 tag, {lk_hit, lk_miss, lk_fault}, lk_paddr, lk_perm,
                 {eh, em, ef}, epa, epm);
      end
    end
  end

  task automatic check(string tag, bit h, bit m, bit f, logic [31:0] pa);
    checks++;
    if ({lk_hit, lk_miss, lk_fault} != {h, m, f} || (h || f) && lk_paddr != pa) begin
      errors++;
      $display("FAIL %s: hmf=%b pa=%h expected hmf=%b pa=%h",
               tag, {lk_hit, lk_miss, lk_fault}, lk_paddr, {h, m, f}, pa);
    end
  endtask

  task automatic look(logic [31:0] va, logic [1:0] acc, string tag,
                      bit h, bit m, bit f, logic [31:0] pa);
    @(posedge clk); #1;
    lk_valid = 1'b1; lk_vaddr = va; lk_acc = acc;
    @(negedge clk);
    check(tag, h, m, f, pa);
  endtask

  task automatic refill(logic [19:0] vpn, logic [19:0] pfn, logic [2:0] pm);
    @(posedge clk); #1;
    fill_en = 1'b1; fill_vpn = vpn; fill_pfn = pfn; fill_perm = pm;
    @(posedge clk); #1;
    fill_en = 1'b0;
  endtask

  task automatic do_flush();
    @(posedge clk); #1;
    flush = 1'b1;
    @(posedge clk); #1;
    flush = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R5 idle outputs
    @(negedge clk);
    check("R5", 0, 0, 0, '0);
    // R1 empty after reset
    look(32'h1234_5678, 2'd0, "R1", 0, 1, 0, '0);

    // R6 lookup during the refill cycle sees old contents
    @(posedge clk); #1;
    fill_en = 1'b1; fill_vpn = 20'h00010; fill_pfn = 20'hABCDE; fill_perm = 3'b011;
    lk_valid = 1'b1; lk_vaddr = 32'h0001_0ABC; lk_acc = 2'd0;
    @(negedge clk);
    check("R6", 0, 1, 0, '0);
    @(posedge clk); #1;
    fill_en = 1'b0;
    @(negedge clk);
    check("R6", 1, 0, 0, 32'hABCD_EABC);

    look(32'h0001_0ABC, 2'd1, "R2", 1, 0, 0, 32'hABCD_EABC);
    look(32'h0001_0ABC, 2'd2, "R4", 0, 0, 1, 32'hABCD_EABC);

    refill(20'h00020, 20'h11111, 3'b101);
    look(32'h0002_0004, 2'd1, "R4", 0, 0, 1, 32'h1111_1004);
    look(32'h0002_0004, 2'd2, "R2", 1, 0, 0, 32'h1111_1004);
    look(32'h0002_0FFF, 2'd3, "R4", 1, 0, 0, 32'h1111_1FFF);

    // R7 overwrite of a page already held
    refill(20'h00010, 20'h22222, 3'b111);
    look(32'h0001_0010, 2'd2, "R7", 1, 0, 0, 32'h2222_2010);

    // R11 flush beats refill in the same cycle
    @(posedge clk); #1;
    flush = 1'b1; fill_en = 1'b1; fill_vpn = 20'h00030; fill_pfn = 20'h33333; fill_perm = 3'b111;
    @(posedge clk); #1;
    flush = 1'b0; fill_en = 1'b0;
    look(32'h0003_0000, 2'd0, "R11", 0, 1, 0, '0);
    look(32'h0001_0000, 2'd0, "R10", 0, 1, 0, '0);

    // R9 rotating replacement when full
    for (int i = 0; i < N; i++) refill(20'h00100 + 20'(i), 20'h00500 + 20'(i), 3'b111);
    look(32'h0011_F008, 2'd0, "R9", 1, 0, 0, 32'h0051_F008);
    refill(20'h00200, 20'h00900, 3'b111);
    look(32'h0010_0000, 2'd0, "R9", 0, 1, 0, '0);
    look(32'h0010_1000, 2'd0, "R9", 1, 0, 0, 32'h0050_1000);
    look(32'h0020_0000, 2'd0, "R9", 1, 0, 0, 32'h0090_0000);
    refill(20'h00201, 20'h00901, 3'b111);
    look(32'h0010_1000, 2'd0, "R9", 0, 1, 0, '0);

    // R10 pointer kept across flush, R8 refills fill lowest free slots
    do_flush();
    for (int i = 0; i < N; i++) refill(20'h00300 + 20'(i), 20'h00700 + 20'(i), 3'b111);
    look(32'h0030_0000, 2'd0, "R8", 1, 0, 0, 32'h0070_0000);
    refill(20'h00400, 20'h00A00, 3'b111);
    look(32'h0030_2000, 2'd0, "R10", 0, 1, 0, '0);
    look(32'h0030_1000, 2'd0, "R8", 1, 0, 0, 32'h0070_1000);
    look(32'h0040_0ABC, 2'd0, "R9", 1, 0, 0, 32'h00A0_0ABC);

    @(posedge clk); #1;
    lk_valid = 1'b0;
    @(negedge clk);
    check("R5", 0, 0, 0, '0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule